// File: doc/BRIEF.md
# Coherent Byte-Access Timer Channel Value Register

This block holds the 16-bit value of one timer channel and exposes it over an 8-bit register bus as a high byte and a low byte. Reading or writing a wide value one byte at a time can tear: the other half may change between the two accesses. The block prevents this in both directions. In capture mode, the first byte read takes a snapshot of the whole value, and the second half is served from that snapshot. In compare and PWM modes, byte writes collect in a staging buffer. The buffer moves into the live register as one coherent 16-bit update.

When that update happens depends on the clock-source select and the channel mode. With the counter stopped, the update is immediate. In compare mode it waits for the next counter advance. In PWM mode it waits for the last step of the period. A debug-freeze input holds all coherency state while it is high, reads return the live value, and byte writes go straight into the live register. A write to the channel's control register clears all coherency state. The counter, the prescaler and the output logic sit outside this block and feed it.

Top module: `tmr_chan_val_reg`

## Requirements
- R1: After reset, `chan_val` is 0x0000, `bus_rdata` reads 0x00 for either byte, and no read snapshot or staged write is pending.
- R2: In capture mode (`chan_mode` = 00), a `cap_evt` loads `cap_val` into `chan_val` at the next clock edge.
- R3: In capture mode, outside debug, the first read (`bus_hi` = 1 selects the high byte, 0 the low byte) returns the live byte and snapshots all 16 bits. Every later read returns the snapshot until the opposite byte has been read. That read returns its snapshot half and releases the snapshot.
- R4: In capture mode, byte writes to the value register never change `chan_val`, with or without debug freeze.
- R5: A `ctl_wr` pulse clears the read snapshot and both staged-byte flags at the next edge, also during debug freeze. It cancels any transfer and any flag setting in the same cycle.
- R6: In compare (01), edge PWM (10) and center PWM (11) modes, outside debug, a byte write only stages that half. The halves may be written in either order, and writing a half again overwrites it. `chan_val` does not change until both halves are staged. A byte written in the transfer cycle is part of the transferred value, and the staged flags clear on transfer.
- R7: With `clk_sel` = 00, the staged value reaches `chan_val` at the edge of the write that completes both halves.
- R8: In compare mode with `clk_sel` nonzero, the transfer takes place on the first cycle after completion in which `cnt_tick` is high.
- R9: In either PWM mode with `clk_sel` nonzero, the transfer takes place on a `cnt_tick` cycle with `cnt_val` equal to `mod_val` - 1. When `mod_val` is 0x0000 the counter is free-running and the trigger value is 0xFFFE.
- R10: While `dbg_freeze` is high, the read snapshot and staged flags keep their values (except for R5), no transfer occurs, and reads return the live bytes. After exit, a pending snapshot is served again.
- R11: While `dbg_freeze` is high in a non-capture mode, a byte write goes directly into that byte of `chan_val` at the next edge and stays there after debug exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_freeze | input | 1 | Debug mode: freezes coherency state and bypasses the buffers |
| ctl_wr | input | 1 | Write strobe of the channel control register; clears coherency state |
| bus_wr | input | 1 | Byte write strobe to the value register |
| bus_rd | input | 1 | Byte read strobe from the value register |
| bus_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational) |
| chan_mode | input | 2 | 00 capture, 01 compare, 10 edge PWM, 11 center PWM |
| clk_sel | input | 2 | Counter clock source; 00 means the counter is stopped |
| cnt_tick | input | 1 | Counter advances this cycle |
| cnt_val | input | 16 | Current counter value |
| mod_val | input | 16 | Modulo value; 0x0000 means free-running |
| cap_evt | input | 1 | Capture event |
| cap_val | input | 16 | Counter value to capture |
| chan_val | output | 16 | Live channel value |

## Verification
The bench targets the following corner cases:
- **Capture between the two halves of a read.** A design that read the live value instead of the snapshot would return a torn value.
- **A repeated read of the same byte.** A design that released the snapshot on any second read would go wrong here.
- **Byte writes in both orders, with one half rewritten.** A design with a fixed high-then-low sequence would transfer early or lose a half.
- **Trigger values just below and at the PWM transfer point, and the free-running modulo.** An off-by-one comparison or a missing zero-modulo rule would move the update one step early or late.
- **Debug entry in the middle of a read, debug bypass writes, and a control write during debug.** A design that let the snapshot release or update during debug would serve the wrong half after exit.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

   typedef enum logic [1:0] {
      CH_CAPTURE    = 2'b00,
      CH_COMPARE    = 2'b01,
      CH_PWM_EDGE   = 2'b10,
      CH_PWM_CENTER = 2'b11
   } ch_mode_e;

   localparam logic [1:0] CLK_STOPPED = 2'b00;

endpackage

// File: rtl/tcv_rd_latch.sv
module tcv_rd_latch
   import tcv_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int VAL_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic              clear,
   input  logic              capture_mode,
   input  logic              rd_en,
   input  logic              rd_hi,
   input  logic [VAL_W-1:0]  live,
   output logic [BYTE_W-1:0] rdata,
   output logic              held
);

   logic              first_hi;
   logic [VAL_W-1:0]  snap;
   logic              use_snap;
   logic [VAL_W-1:0]  src;

   assign use_snap = held && capture_mode && !freeze;
   assign src      = use_snap ? snap : live;
   assign rdata    = rd_hi ? src[VAL_W-1:BYTE_W] : src[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         first_hi <= 1'b0;
         snap     <= '0;
      end else if (clear) begin
         held <= 1'b0;
      end else if (!freeze && capture_mode && rd_en) begin
         if (!held) begin
            held     <= 1'b1;
            first_hi <= rd_hi;
            snap     <= live;
         end else if (rd_hi != first_hi) begin
            held <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tcv_wr_buffer.sv
module tcv_wr_buffer
   import tcv_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int VAL_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              accept,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              xfer,
   output logic [VAL_W-1:0]  stage_q,
   output logic [VAL_W-1:0]  stage_d,
   output logic              hi_full,
   output logic              lo_full,
   output logic              both_now,
   output logic              both_next
);

   logic hi_set, lo_set;

   assign hi_set    = accept && wr_hi;
   assign lo_set    = accept && !wr_hi;
   assign both_now  = hi_full && lo_full;
   assign both_next = (hi_full || hi_set) && (lo_full || lo_set);

   always_comb begin
      stage_d = stage_q;
      if (hi_set) stage_d[VAL_W-1:BYTE_W] = wdata;
      if (lo_set) stage_d[BYTE_W-1:0]     = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         hi_full <= 1'b0;
         lo_full <= 1'b0;
      end else begin
         stage_q <= stage_d;
         if (clear || xfer) begin
            hi_full <= 1'b0;
            lo_full <= 1'b0;
         end else begin
            if (hi_set) hi_full <= 1'b1;
            if (lo_set) lo_full <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tcv_xfer_ctrl.sv
module tcv_xfer_ctrl
   import tcv_pkg::*;
#(
   parameter int VAL_W          = 16,
   parameter bit ZERO_MOD_FREE  = 1'b1
) (
   input  logic             freeze,
   input  logic             clear,
   input  ch_mode_e         mode,
   input  logic [1:0]       clk_sel,
   input  logic             both_now,
   input  logic             both_next,
   input  logic             cnt_tick,
   input  logic [VAL_W-1:0] cnt_val,
   input  logic [VAL_W-1:0] mod_val,
   output logic             xfer
);

   logic [VAL_W-1:0] period_end;
   logic             pwm_hit;

   generate
      if (ZERO_MOD_FREE) begin : g_free_run
         assign period_end = (mod_val == '0) ? {VAL_W{1'b1}} : mod_val;
      end else begin : g_plain_mod
         assign period_end = mod_val;
      end
   endgenerate

   assign pwm_hit = cnt_tick && (cnt_val == period_end - 1'b1);

   always_comb begin
      xfer = 1'b0;
      if (!freeze && !clear && mode != CH_CAPTURE) begin
         if (clk_sel == CLK_STOPPED)   xfer = both_next;
         else if (mode == CH_COMPARE)  xfer = both_now && cnt_tick;
         else                          xfer = both_now && pwm_hit;
      end
   end

endmodule

// File: rtl/tmr_chan_val_reg.sv
module tmr_chan_val_reg
   import tcv_pkg::*;
#(
   parameter int BYTE_W         = 8,
   parameter bit ZERO_MOD_FREE  = 1'b1,
   localparam int VAL_W         = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_freeze,
   input  logic              ctl_wr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_hi,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [1:0]        chan_mode,
   input  logic [1:0]        clk_sel,
   input  logic              cnt_tick,
   input  logic [VAL_W-1:0]  cnt_val,
   input  logic [VAL_W-1:0]  mod_val,
   input  logic              cap_evt,
   input  logic [VAL_W-1:0]  cap_val,
   output logic [VAL_W-1:0]  chan_val
);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("tmr_chan_val_reg: BYTE_W must be at least 2");
      end
   endgenerate

   ch_mode_e          mode;
   logic              is_capture;
   logic              wb_accept;
   logic [VAL_W-1:0]  wb_stage_q, wb_stage_d;
   logic              wb_hi_full, wb_lo_full, wb_both_now, wb_both_next;
   logic              do_xfer;
   logic              rd_held;

   assign mode       = ch_mode_e'(chan_mode);
   assign is_capture = (mode == CH_CAPTURE);
   assign wb_accept  = bus_wr && !is_capture && !dbg_freeze;

   tcv_rd_latch #(.BYTE_W(BYTE_W)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .freeze       (dbg_freeze),
      .clear        (ctl_wr),
      .capture_mode (is_capture),
      .rd_en        (bus_rd),
      .rd_hi        (bus_hi),
      .live         (chan_val),
      .rdata        (bus_rdata),
      .held         (rd_held)
   );

   tcv_wr_buffer #(.BYTE_W(BYTE_W)) u_wb (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ctl_wr),
      .accept    (wb_accept),
      .wr_hi     (bus_hi),
      .wdata     (bus_wdata),
      .xfer      (do_xfer),
      .stage_q   (wb_stage_q),
      .stage_d   (wb_stage_d),
      .hi_full   (wb_hi_full),
      .lo_full   (wb_lo_full),
      .both_now  (wb_both_now),
      .both_next (wb_both_next)
   );

   tcv_xfer_ctrl #(.VAL_W(VAL_W), .ZERO_MOD_FREE(ZERO_MOD_FREE)) u_xc (
      .freeze    (dbg_freeze),
      .clear     (ctl_wr),
      .mode      (mode),
      .clk_sel   (clk_sel),
      .both_now  (wb_both_now),
      .both_next (wb_both_next),
      .cnt_tick  (cnt_tick),
      .cnt_val   (cnt_val),
      .mod_val   (mod_val),
      .xfer      (do_xfer)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_val <= '0;
      end else if (is_capture) begin
         if (cap_evt) chan_val <= cap_val;
      end else if (do_xfer) begin
         chan_val <= wb_stage_d;
      end else if (dbg_freeze && bus_wr) begin
         if (bus_hi) chan_val[VAL_W-1:BYTE_W] <= bus_wdata;
         else        chan_val[BYTE_W-1:0]     <= bus_wdata;
      end
   end

endmodule

// File: rtl/tcv_chk.sv
module tcv_chk #(
   parameter int VAL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dbg_freeze,
   input logic             ctl_wr,
   input logic             bus_wr,
   input logic [1:0]       chan_mode,
   input logic [1:0]       clk_sel,
   input logic             cap_evt,
   input logic             cnt_tick,
   input logic [VAL_W-1:0] cnt_val,
   input logic [VAL_W-1:0] mod_val,
   input logic [VAL_W-1:0] chan_val,
   input logic [VAL_W-1:0] stage_q,
   input logic             hi_full,
   input logic             lo_full,
   input logic             rd_held
);

   logic [VAL_W-1:0] trig_val;
   assign trig_val = (mod_val == '0) ? {{(VAL_W-1){1'b1}}, 1'b0} : mod_val - 1'b1;

   // R4
   capture_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode == 2'b00 && bus_wr && !cap_evt) |=> $stable(chan_val));

   // R5
   ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (!hi_full && !lo_full && !rd_held));

   // R10
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_freeze && !ctl_wr) |=> $stable({hi_full, lo_full, rd_held}));

   // R6
   no_early_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_freeze && chan_mode != 2'b00 && !(hi_full && lo_full) && !bus_wr)
      |=> $stable(chan_val));

   // R9
   pwm_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_freeze && !ctl_wr && !bus_wr && chan_mode[1] && clk_sel != 2'b00 &&
       hi_full && lo_full && cnt_tick && cnt_val == trig_val)
      |=> chan_val == $past(stage_q));

endmodule

bind tmr_chan_val_reg tcv_chk #(.VAL_W(VAL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_freeze (dbg_freeze),
   .ctl_wr     (ctl_wr),
   .bus_wr     (bus_wr),
   .chan_mode  (chan_mode),
   .clk_sel    (clk_sel),
   .cap_evt    (cap_evt),
   .cnt_tick   (cnt_tick),
   .cnt_val    (cnt_val),
   .mod_val    (mod_val),
   .chan_val   (chan_val),
   .stage_q    (wb_stage_q),
   .hi_full    (wb_hi_full),
   .lo_full    (wb_lo_full),
   .rd_held    (rd_held)
);

// File: tb/tmr_chan_val_reg_bench.sv
module tmr_chan_val_reg_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_freeze = 0, ctl_wr = 0, bus_wr = 0, bus_rd = 0, bus_hi = 0;
   logic [7:0]  bus_wdata = 0;
   logic [7:0]  bus_rdata;
   logic [1:0]  chan_mode = 0, clk_sel = 0;
   logic        cnt_tick = 0, cap_evt = 0;
   logic [15:0] cnt_val = 0, mod_val = 0, cap_val = 0;
   logic [15:0] chan_val;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   string req = "R1";

   // reference state
   int m_live = 0, m_snap = 0, m_stage = 0;
   bit m_held = 0, m_first_hi = 0, m_fhi = 0, m_flo = 0;

   always #2.5 clk = ~clk;

   tmr_chan_val_reg u_tmr_chan_val_reg (.*);

   function automatic int sel_byte(int v, bit hi);
      return hi ? ((v >> 8) & 255) : (v & 255);
   endfunction

   task automatic compare();
      int exp_rd;
      exp_rd = sel_byte((m_held && chan_mode == 0 && !dbg_freeze) ? m_snap : m_live, bus_hi);
      n_cmp++;
      if (int'(chan_val) != m_live) begin
         n_bad++;
         $display("FAIL %s chan_val actual=%h expected=%h", req, chan_val, m_live[15:0]);
      end
      n_cmp++;
      if (int'(bus_rdata) != exp_rd) begin
         n_bad++;
         $display("FAIL %s bus_rdata actual=%h expected=%h", req, bus_rdata, exp_rd[7:0]);
      end
   endtask

   task automatic model_step();
      bit cap, acc, hs, ls, bn, bnow, hit, xf;
      int nstage, endv;
      cap = (chan_mode == 0);
      acc = bus_wr && !cap && !dbg_freeze;
      hs = acc && bus_hi; ls = acc && !bus_hi;
      nstage = m_stage;
      if (hs) nstage = (nstage & 255) | (int'(bus_wdata) << 8);
      if (ls) nstage = (nstage & 65280) | int'(bus_wdata);
      bnow = m_fhi && m_flo;
      bn = (m_fhi || hs) && (m_flo || ls);
      endv = (mod_val == 0) ? 65535 : int'(mod_val);
      hit = cnt_tick && (int'(cnt_val) == endv - 1);
      xf = 0;
      if (!dbg_freeze && !ctl_wr && !cap) begin
         if (clk_sel == 0) xf = bn;
         else if (chan_mode == 1) xf = bnow && cnt_tick;
         else xf = bnow && hit;
      end
      // read snapshot
      if (ctl_wr) m_held = 0;
      else if (!dbg_freeze && cap && bus_rd) begin
         if (!m_held) begin m_held = 1; m_first_hi = bus_hi; m_snap = m_live; end
         else if (bus_hi != m_first_hi) m_held = 0;
      end
      // live value
      if (cap) begin
         if (cap_evt) m_live = int'(cap_val);
      end else if (xf) m_live = nstage;
      else if (dbg_freeze && bus_wr) begin
         if (bus_hi) m_live = (m_live & 255) | (int'(bus_wdata) << 8);
         else        m_live = (m_live & 65280) | int'(bus_wdata);
      end
      m_stage = nstage;
      if (ctl_wr || xf) begin m_fhi = 0; m_flo = 0; end
      else begin if (hs) m_fhi = 1; if (ls) m_flo = 1; end
   endtask

   // one cycle: inputs already driven after a negedge
   task automatic tick();
      #1 compare();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; ctl_wr = 0; cap_evt = 0; cnt_tick = 0;
   endtask

   task automatic wr(bit hi, logic [7:0] d);
      bus_wr = 1; bus_hi = hi; bus_wdata = d; tick();
   endtask

   task automatic rd(bit hi);
      bus_rd = 1; bus_hi = hi; tick();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      req = "R1"; #1 compare(); bus_hi = 1; #1 compare();
      @(negedge clk); rst_n = 1;
      idle(2);

      req = "R2"; chan_mode = 0;
      cap_evt = 1; cap_val = 16'h1234; tick(); idle(1);

      req = "R3";
      rd(1);                                  // high first, snapshot 1234
      cap_evt = 1; cap_val = 16'hABCD; tick();
      rd(1);                                  // same byte again: still buffered
      rd(0);                                  // returns 34 from snapshot, releases
      rd(0);                                  // live low byte CD
      rd(1);                                  // releases
      cap_evt = 1; cap_val = 16'h5A5A; bus_rd = 1; bus_hi = 0; tick();
      rd(1);

      req = "R4"; wr(1, 8'hEE); wr(0, 8'h11);
      dbg_freeze = 1; wr(1, 8'h77); dbg_freeze = 0; idle(1);

      req = "R5"; rd(0); ctl_wr = 1; tick(); rd(1); rd(0); rd(1);

      req = "R6"; chan_mode = 1; clk_sel = 0;
      wr(0, 8'h22); idle(2); wr(0, 8'h23);
      req = "R7"; wr(1, 8'h99); idle(1);
      wr(1, 8'h44); wr(0, 8'h55); idle(1);

      req = "R5"; wr(0, 8'h66); ctl_wr = 1; tick(); wr(1, 8'h01); idle(1);
      ctl_wr = 1; bus_wr = 1; bus_hi = 0; bus_wdata = 8'h02; tick(); wr(1, 8'h03); idle(1);

      req = "R8"; clk_sel = 2'b01;
      wr(1, 8'hC0); wr(0, 8'hDE); idle(2);
      cnt_tick = 1; tick(); idle(1);
      wr(0, 8'h10); cnt_tick = 1; bus_wr = 1; bus_hi = 1; bus_wdata = 8'h20; tick();
      cnt_tick = 1; tick();

      req = "R9"; chan_mode = 2; mod_val = 16'h0010;
      wr(0, 8'h08); wr(1, 8'h00);
      cnt_val = 16'h000E; cnt_tick = 1; tick();
      cnt_val = 16'h000F; tick();
      cnt_tick = 1; tick(); idle(1);
      chan_mode = 3; mod_val = 0; wr(1, 8'h7F); wr(0, 8'hF0);
      cnt_val = 16'hFFFF; cnt_tick = 1; tick();
      cnt_val = 16'hFFFE; cnt_tick = 1; tick(); idle(1);

      req = "R10"; chan_mode = 0; clk_sel = 0;
      cap_evt = 1; cap_val = 16'h3C4D; tick();
      rd(0);
      cap_evt = 1; cap_val = 16'h8899; tick();
      dbg_freeze = 1; rd(1); rd(0); rd(1);
      dbg_freeze = 0; rd(1); rd(0);
      chan_mode = 1; clk_sel = 0; wr(0, 8'hAA);
      dbg_freeze = 1; wr(1, 8'hBB); idle(1);
      req = "R5"; ctl_wr = 1; tick();
      req = "R11"; wr(1, 8'h5E); wr(0, 8'h6F); chan_mode = 2; clk_sel = 1;
      wr(1, 8'h12); dbg_freeze = 0; idle(2);
      wr(0, 8'h34); cnt_tick = 1; tick(); idle(1);

      req = "R6";
      for (int i = 0; i < 1500; i++) begin
         dbg_freeze = ($urandom_range(0, 19) == 0);
         ctl_wr     = ($urandom_range(0, 24) == 0);
         bus_wr     = $urandom_range(0, 1);
         bus_rd     = $urandom_range(0, 1);
         bus_hi     = $urandom_range(0, 1);
         bus_wdata  = 8'($urandom);
         if ($urandom_range(0, 15) == 0) chan_mode = 2'($urandom);
         if ($urandom_range(0, 15) == 0) clk_sel = 2'($urandom);
         cnt_tick = $urandom_range(0, 1);
         cnt_val  = 16'($urandom_range(0, 9));
         mod_val  = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'h0008;
         if (mod_val == 0 && cnt_val == 7) cnt_val = 16'hFFFE;
         cap_evt  = $urandom_range(0, 1);
         cap_val  = 16'($urandom);
         tick();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule